// File: doc/BRIEF.md
# Double-Data-Rate 10:1 Lane Serializer

This block turns one 10-bit line character per pixel clock into a serial stream on a single lane. It works beside a second clock that runs five times faster than the pixel clock and is phase aligned to it. Each fast cycle carries two bit slots: the first is the even bit, meant for the rising edge, and the second is the odd bit, meant for the falling edge. Ten slots therefore carry one character per pixel period. The 2-bit stream comes out as a plain pair and also as a complementary p/n copy. A later double-data-rate output cell combines each pair onto one pin.

The character is registered in the pixel domain. A toggle flag marks each new character, and the fast domain synchronises that flag. The flag's edge loads a 10-bit shift register, and a modulo-5 phase counter runs in step with those loads. Every fast cycle the register presents its two lowest bits and then shifts right by two. Bits leave the lane in ascending order, starting at bit 0.

A mode input replaces the character with a fixed clock-lane word whose upper five bits are ones and whose lower five bits are zeros. This gives a lane that toggles once per pixel period. An active-high synchronous reset drives the lane to zero.

Top module: `tmds_ddr_serializer`

## Requirements
- R1: Each character captured on a pixel clock edge produces exactly five output pairs on consecutive fast cycles. The next character's pairs follow immediately, with no gap and no repeat.
- R2: Pair k of a character w (k = 0..4) is lane_pair[0] = w[2k] (even, rising-edge slot) and lane_pair[1] = w[2k+1] (odd, falling-edge slot). Bits leave least significant first.
- R3: Between loads, the 10-bit shift register moves right by two bit positions on every fast clock edge.
- R4: lane_p equals lane_pair, and lane_n is the bitwise inverse of lane_p at all times.
- R5: While clk_mode is 1 at a pixel edge, the captured character is 10'b1111100000 (bit 9 down to bit 0). On the lane this appears as five zeros followed by five ones, every pixel period without drift.
- R6: While rst is 1, lane_pair and lane_p are 2'b00 from the first fast edge onward, and lane_n is 2'b11.
- R7: A character sampled on a pixel clock edge loads into the shift register on the second fast edge after that pixel edge. Its pair 0 is therefore visible from 16 ns to 24 ns after the edge at the default clock ratio. This latency is the same for every character, including the first one after reset.
- R8: Once running, a load occurs only when the modulo-5 phase counter is at 4. Loads are never closer than five fast cycles apart.
- R9: In clock-lane mode the value on word_in has no effect on the lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock; the character is sampled on its rising edge |
| fast_clk | input | 1 | Clock at five times the pixel rate, phase aligned with pix_clk |
| rst | input | 1 | Active-high synchronous reset, applied in both domains |
| word_in | input | 10 | Parallel character, pixel clock domain |
| clk_mode | input | 1 | 1 selects the constant clock-lane character |
| lane_pair | output | 2 | Current slot pair: bit 0 even (rising), bit 1 odd (falling) |
| lane_p | output | 2 | True copy of the slot pair |
| lane_n | output | 2 | Inverted copy of the slot pair |

## Verification
The bench rebuilds every character from the five pairs it samples between pixel edges. It first drives a fixed set of characters: all zeros, all ones, both alternating patterns, single set bits at each end, and half-filled words. These separate a correct LSB-first order from a swapped pair, a reversed word or a wrong shift stride. Clock-lane mode is then driven with changing, random word_in values, which shows whether the constant character really masks the input and whether the five-zero, five-one pattern slips over many periods. A reset in mid-stream, followed by fresh characters, checks that the outputs clear and that the load latency comes back at the same fast edge.

// File: rtl/tser_pkg.sv
package tser_pkg;

    // Source of the character loaded in the pixel domain.
    typedef enum logic {
        SRC_DATA  = 1'b0,
        SRC_CLOCK = 1'b1
    } word_src_e;

    localparam int unsigned DEF_WORD_W    = 10;
    localparam int unsigned DEF_LANE_BITS = 2;

    // Word of width w with its upper half set and lower half clear.
    function automatic logic [63:0] half_high_ones(int unsigned w);
        logic [63:0] r;
        r = '0;
        for (int unsigned i = 0; i < 64; i++) begin
            if (i < w && i >= w / 2) begin
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/tser_pix_capture.sv
module tser_pix_capture
    import tser_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic              pix_clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    input  logic              clk_mode,
    output logic [WORD_W-1:0] word_q,
    output logic              flag_q
);
    localparam logic [WORD_W-1:0] CLK_WORD = WORD_W'(half_high_ones(WORD_W));

    word_src_e src;
    assign src = clk_mode ? SRC_CLOCK : SRC_DATA;

    always_ff @(posedge pix_clk) begin
        if (rst) begin
            word_q <= '0;
            flag_q <= 1'b0;
        end else begin
            word_q <= (src == SRC_CLOCK) ? CLK_WORD : word_in;
            flag_q <= ~flag_q;
        end
    end

endmodule

// File: rtl/tser_load_sync.sv
module tser_load_sync #(
    parameter int unsigned RATIO = 5,
    localparam int unsigned CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic             fast_clk,
    input  logic             rst,
    input  logic             flag_in,
    output logic             load,
    output logic [CNT_W-1:0] phase,
    output logic             locked
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

    logic [1:0] sync_q;

    always_ff @(posedge fast_clk) begin
        if (rst) begin
            sync_q <= 2'b00;
        end else begin
            sync_q <= {sync_q[0], flag_in};
        end
    end

    // A change of the pixel-domain flag marks one new character.
    assign load = sync_q[0] ^ sync_q[1];

    always_ff @(posedge fast_clk) begin
        if (rst) begin
            phase  <= '0;
            locked <= 1'b0;
        end else begin
            if (load || phase == LAST) begin
                phase <= '0;
            end else begin
                phase <= phase + 1'b1;
            end
            if (load) begin
                locked <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tser_shifter.sv
module tser_shifter #(
    parameter int unsigned WORD_W    = 10,
    parameter int unsigned LANE_BITS = 2
) (
    input  logic                 fast_clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [WORD_W-1:0]    word,
    output logic [WORD_W-1:0]    shreg,
    output logic [LANE_BITS-1:0] slots
);
    always_ff @(posedge fast_clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= word;
        end else begin
            shreg <= shreg >> LANE_BITS;
        end
    end

    assign slots = shreg[LANE_BITS-1:0];

endmodule

// File: rtl/tmds_ddr_serializer.sv
module tmds_ddr_serializer
    import tser_pkg::*;
#(
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned LANE_BITS = DEF_LANE_BITS
) (
    input  logic                 pix_clk,
    input  logic                 fast_clk,
    input  logic                 rst,
    input  logic [WORD_W-1:0]    word_in,
    input  logic                 clk_mode,
    output logic [LANE_BITS-1:0] lane_pair,
    output logic [LANE_BITS-1:0] lane_p,
    output logic [LANE_BITS-1:0] lane_n
);
    localparam int unsigned RATIO = WORD_W / LANE_BITS;
    localparam int unsigned CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic [WORD_W-1:0]    word_q_w;
    logic                 flag_w;
    logic                 load_w;
    logic [CNT_W-1:0]     phase_w;
    logic                 locked_w;
    logic [WORD_W-1:0]    shreg_w;
    logic [LANE_BITS-1:0] slots_w;

    tser_pix_capture #(.WORD_W(WORD_W)) u_cap (
        .pix_clk  (pix_clk),
        .rst      (rst),
        .word_in  (word_in),
        .clk_mode (clk_mode),
        .word_q   (word_q_w),
        .flag_q   (flag_w)
    );

    tser_load_sync #(.RATIO(RATIO)) u_sync (
        .fast_clk (fast_clk),
        .rst      (rst),
        .flag_in  (flag_w),
        .load     (load_w),
        .phase    (phase_w),
        .locked   (locked_w)
    );

    tser_shifter #(.WORD_W(WORD_W), .LANE_BITS(LANE_BITS)) u_shift (
        .fast_clk (fast_clk),
        .rst      (rst),
        .load     (load_w),
        .word     (word_q_w),
        .shreg    (shreg_w),
        .slots    (slots_w)
    );

    assign lane_pair = slots_w;

    for (genvar g = 0; g < LANE_BITS; g++) begin : g_diff
        assign lane_p[g] = slots_w[g];
        assign lane_n[g] = ~slots_w[g];
    end

endmodule

// File: rtl/tser_checker.sv
module tser_checker
    import tser_pkg::*;
#(
    parameter int unsigned WORD_W    = 10,
    parameter int unsigned LANE_BITS = 2,
    parameter int unsigned RATIO     = 5,
    localparam int unsigned CNT_W    = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input logic                 pix_clk,
    input logic                 fast_clk,
    input logic                 rst,
    input logic                 clk_mode,
    input logic [WORD_W-1:0]    word_q,
    input logic                 load,
    input logic                 locked,
    input logic [CNT_W-1:0]     phase,
    input logic [WORD_W-1:0]    shreg,
    input logic [LANE_BITS-1:0] lane_pair,
    input logic [LANE_BITS-1:0] lane_n
);
    localparam logic [WORD_W-1:0] CLK_WORD = WORD_W'(half_high_ones(WORD_W));

    // R6: reset clears the lane on the following fast edge
    a_r6_reset_clears: assert property (@(posedge fast_clk)
        rst |=> (lane_pair == '0 && lane_n == '1));

    // R7: a load copies the pixel-domain character into the shift register
    a_r7_load_takes_word: assert property (@(posedge fast_clk) disable iff (rst)
        load |=> shreg == $past(word_q));

    // R3: shift by two positions when no load occurs
    a_r3_shift_by_two: assert property (@(posedge fast_clk) disable iff (rst)
        !load |=> shreg == ($past(shreg) >> LANE_BITS));

    // R8: loads land on the last phase of the modulo counter
    a_r8_load_phase: assert property (@(posedge fast_clk) disable iff (rst)
        (load && locked) |-> phase == CNT_W'(RATIO - 1));

    // R1: no two loads on adjacent fast cycles
    a_r1_load_spacing: assert property (@(posedge fast_clk) disable iff (rst)
        load |=> !load);

    // R5: clock-lane mode captures the constant character
    a_r5_clock_word: assert property (@(posedge pix_clk) disable iff (rst)
        clk_mode |=> word_q == CLK_WORD);

endmodule

bind tmds_ddr_serializer tser_checker #(
    .WORD_W    (WORD_W),
    .LANE_BITS (LANE_BITS),
    .RATIO     (RATIO)
) u_tser_chk (
    .pix_clk   (pix_clk),
    .fast_clk  (fast_clk),
    .rst       (rst),
    .clk_mode  (clk_mode),
    .word_q    (word_q_w),
    .load      (load_w),
    .locked    (locked_w),
    .phase     (phase_w),
    .shreg     (shreg_w),
    .lane_pair (lane_pair),
    .lane_n    (lane_n)
);

// File: tb/test_tmds_ddr_serializer.sv
module test_tmds_ddr_serializer;

    logic       fclk = 1'b0;
    logic       pclk = 1'b0;
    logic       rst  = 1'b1;
    logic [9:0] din  = '0;
    logic       mode = 1'b0;
    logic [1:0] pair, lp, ln;

    int checks = 0;
    int fails  = 0;

    localparam logic [9:0] CLK_WORD = 10'b1111100000;

    // {mode, din, expected character}
    localparam int NVEC = 14;
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 10'h000, 10'h000},
        {1'b0, 10'h3FF, 10'h3FF},
        {1'b0, 10'h155, 10'h155},
        {1'b0, 10'h2AA, 10'h2AA},
        {1'b0, 10'h001, 10'h001},
        {1'b0, 10'h200, 10'h200},
        {1'b0, 10'h3E0, 10'h3E0},
        {1'b0, 10'h01F, 10'h01F},
        {1'b0, 10'h1B4, 10'h1B4},
        {1'b0, 10'h2C7, 10'h2C7},
        {1'b1, 10'h123, 10'h3E0},
        {1'b1, 10'h0AB, 10'h3E0},
        {1'b0, 10'h36D, 10'h36D},
        {1'b1, 10'h3FF, 10'h3E0}
    };

    tmds_ddr_serializer i_tmds_ddr_serializer (
        .pix_clk   (pclk),
        .fast_clk  (fclk),
        .rst       (rst),
        .word_in   (din),
        .clk_mode  (mode),
        .lane_pair (pair),
        .lane_p    (lp),
        .lane_n    (ln)
    );

    initial forever #4  fclk = ~fclk;
    initial forever #20 pclk = ~pclk;

    logic [9:0] prev_acc, cur_acc, prev_exp, pend_exp;
    logic       prev_valid = 1'b0;

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // One pixel period: the edge captures the driven character, new inputs
    // follow, five pairs are sampled at fast falling edges.
    task automatic drive_step(input logic nmode, input logic [9:0] ndin,
                              input logic [9:0] nexp, input string tag);
        logic [9:0] cap_exp;
        cap_exp = pend_exp;
        @(posedge pclk);
        #1;
        mode = nmode;
        din  = ndin;
        for (int j = 0; j < 5; j++) begin
            @(negedge fclk);
            check("R4 p copy", {8'h0, lp}, {8'h0, pair});
            check("R4 n inverse", {8'h0, ln}, {8'h0, ~lp});
            if (j < 2) prev_acc[2*(j+3) +: 2] = pair;
            else       cur_acc[2*(j-2) +: 2]  = pair;
            if (j == 1 && prev_valid) check(tag, prev_acc, prev_exp);
        end
        prev_acc   = cur_acc;
        prev_exp   = cap_exp;
        prev_valid = 1'b1;
        pend_exp   = nexp;
    endtask

    task automatic mid_reset();
        @(posedge pclk);
        #1 rst = 1'b1;
        @(negedge fclk);
        for (int j = 0; j < 3; j++) begin
            @(negedge fclk);
            check("R6 pair cleared", {8'h0, pair}, 10'h000);
            check("R6 n high", {8'h0, ln}, 10'h003);
        end
        @(posedge pclk);
        #1 rst = 1'b0;
        prev_valid = 1'b0;
    endtask

    initial begin : watchdog
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [20:0] nxt;
        logic [9:0]  rnd;
        // R6: reset state
        repeat (2) @(posedge pclk);
        for (int j = 0; j < 2; j++) begin
            @(negedge fclk);
            check("R6 reset pair", {8'h0, pair}, 10'h000);
            check("R6 reset p", {8'h0, lp}, 10'h000);
            check("R6 reset n", {8'h0, ln}, 10'h003);
        end
        @(posedge pclk);
        #1;
        rst      = 1'b0;
        mode     = VEC[0][20];
        din      = VEC[0][19:10];
        pend_exp = VEC[0][9:0];

        // Table walk: R1 R2 R3 R7, mode rows R5 R9
        for (int i = 0; i < NVEC; i++) begin
            nxt = (i < NVEC - 1) ? VEC[i+1] : 21'h0;
            drive_step(nxt[20], nxt[19:10], nxt[9:0], "R1 R2 R3 R7 R9 word rebuild");
        end

        // Long clock-lane run with changing data: R5 R8 R9
        for (int k = 0; k < 12; k++) begin
            rnd = 10'($urandom);
            drive_step(1'b1, rnd, CLK_WORD, "R5 R8 R9 clock lane pattern");
        end

        // Reset in mid-stream, then latency must return unchanged: R6 R7
        mid_reset();
        mode     = 1'b0;
        din      = 10'h2D3;
        pend_exp = 10'h2D3;
        for (int k = 0; k < 6; k++) begin
            rnd = 10'($urandom);
            drive_step(1'b0, rnd, rnd, "R7 latency after reset");
        end
        drive_step(1'b0, 10'h000, 10'h000, "R1 final flush");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule